// File: doc/BRIEF.md
# Over-current hiccup fault controller

This block sits in the protection path of a switching regulator. It receives a one-clock tick per switching cycle, a per-cycle over-current flag from the current comparator, the power-good level and an under-voltage flag that means the sensed output has dropped below half of its set-point. When a qualifying fault appears, it takes the gate drivers out of normal switching. First the low side is held on so the inductor drains. Then both switches are held off for a blanking interval. After that it requests a restart.

A trip happens after a run of consecutive over-current cycles seen while power-good is low, or at once on output collapse. After each restart the block returns to normal operation. If the over-current is still there, the trip path fires again, so the block keeps hiccuping until the overload is gone. The restart pulse is meant for an external soft-start ramp.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it is released, hs_en=1, ls_en=0, fault=0 and restart=0. This is the run state.
- R2: In the run state, a tick is qualifying when oc_flag=1 and pgood=0. The clock edge that samples the TRIP_CNT-th consecutive qualifying tick (default 16) moves the block to the drain state. In that state hs_en=0, ls_en=1 and fault=1. Fewer qualifying ticks leave the outputs unchanged.
- R3: A tick with oc_flag=0, or a tick with pgood=1, resets the consecutive count to zero. Clock cycles without a tick leave the count unchanged.
- R4: In the run state, uv_flag=1 moves the block to the drain state at the next clock edge, whatever the count is.
- R5: The drain state holds hs_en=0, ls_en=1 and fault=1 until an edge samples zc_flag=1. That edge enters the off state.
- R6: The off state drives hs_en=0, ls_en=0 and fault=1 for exactly BLANK_CYC clock cycles (default 65536). It then returns to the run state.
- R7: restart is high for exactly the first cycle of the run state after the off state. The consecutive count starts from zero, so a persisting overload trips again after TRIP_CNT more qualifying ticks.
- R8: hs_en and ls_en are never high in the same cycle.
- R9: zc_flag has no effect outside the drain state. oc_flag, pgood, uv_flag and cyc_tick have no effect in the drain and off states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| oc_flag | input | 1 | Over-current seen in the current switching cycle |
| pgood | input | 1 | Power-good level |
| uv_flag | input | 1 | Output below half of the set-point |
| zc_flag | input | 1 | Inductor current has reached zero |
| hs_en | output | 1 | High-side enable (normal switching allowed) |
| ls_en | output | 1 | Low-side forced-on enable for draining |
| fault | output | 1 | Fault sequence in progress |
| restart | output | 1 | One-cycle pulse requesting a soft-start re-ramp |

## Verification
The bench aims at the edge of the trip count. Fifteen qualifying ticks must not trip and the sixteenth must, so an off-by-one counter would trip a cycle early or late. A clean tick or a power-good tick inside the run must restart the count; a design that only paused the count would trip too soon. Idle clocks between ticks must not clear the count. The bench also checks that zero-current and under-voltage arriving in the wrong state are ignored, that the off time is exactly as long as the parameter, and that a persisting overload leads to a second full hiccup. A wrong blanking length shows up as a restart pulse that comes early or late.

// File: rtl/ocp_hiccup_pkg.sv
package ocp_hiccup_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_OFF   = 2'd2
    } hic_state_e;

endpackage

// File: rtl/ocp_trip_count.sv
// Counts consecutive qualifying switching cycles (over-current with power-good low).
module ocp_trip_count #(
    parameter int TRIP_CNT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic oc,
    input  logic pgood,
    output logic trip
);
    localparam int CW = $clog2(TRIP_CNT + 1);
    localparam logic [CW-1:0] TOP  = CW'(TRIP_CNT);
    localparam logic [CW-1:0] LAST = CW'(TRIP_CNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;
    logic qual;

    always_comb begin
        qual = tick & oc & ~pgood;
        r_d  = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (tick) begin
            if (!qual)
                r_d.cnt = '0;
            else if (r_q.cnt != TOP)
                r_d.cnt = r_q.cnt + 1'b1;
        end
        trip = ~clr & qual & (r_q.cnt >= LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/ocp_blank_timer.sv
// Measures the all-off interval; done marks its last cycle.
module ocp_blank_timer #(
    parameter int BLANK_CYC = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int TW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(BLANK_CYC - 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
    } tmr_reg_t;

    tmr_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run)
            r_d.tmr = '0;
        else if (r_q.tmr != LAST)
            r_d.tmr = r_q.tmr + 1'b1;
        done = run & (r_q.tmr == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl #(
    parameter int TRIP_CNT  = 16,
    parameter int BLANK_CYC = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_tick,
    input  logic oc_flag,
    input  logic pgood,
    input  logic uv_flag,
    input  logic zc_flag,
    output logic hs_en,
    output logic ls_en,
    output logic fault,
    output logic restart
);
    import ocp_hiccup_pkg::*;

    typedef struct packed {
        hic_state_e st;
        logic       rst_pls;
    } ctl_reg_t;

    ctl_reg_t r_d, r_q;
    logic trip, blank_done;

    ocp_trip_count #(.TRIP_CNT(TRIP_CNT)) i_trip (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_q.st != ST_RUN),
        .tick  (cyc_tick),
        .oc    (oc_flag),
        .pgood (pgood),
        .trip  (trip)
    );

    ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == ST_OFF),
        .done  (blank_done)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rst_pls = 1'b0;
        case (r_q.st)
            ST_RUN: begin
                if (trip || uv_flag) r_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (zc_flag) r_d.st = ST_OFF;
            end
            ST_OFF: begin
                if (blank_done) begin
                    r_d.st      = ST_RUN;
                    r_d.rst_pls = 1'b1;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_RUN, rst_pls: 1'b0};
        else        r_q <= r_d;
    end

    assign hs_en   = (r_q.st == ST_RUN);
    assign ls_en   = (r_q.st == ST_DRAIN);
    assign fault   = (r_q.st != ST_RUN);
    assign restart = r_q.rst_pls;
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
    parameter int BLANK_CYC = 65536
) (
    input logic clk,
    input logic rst_n,
    input logic uv_flag,
    input logic zc_flag,
    input logic hs_en,
    input logic ls_en,
    input logic fault,
    input logic restart
);
    localparam int LW = $clog2(BLANK_CYC + 1);
    localparam logic [LW-1:0] FULL = LW'(BLANK_CYC);

    logic [LW-1:0] off_len_q;
    logic          off_now;

    assign off_now = fault && !ls_en;

    always_ff @(posedge clk) begin
        if (!rst_n)       off_len_q <= '0;
        else if (off_now) off_len_q <= (off_len_q == FULL) ? off_len_q : off_len_q + 1'b1;
        else              off_len_q <= '0;
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    p_uv_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && uv_flag) |=> (fault && ls_en));

    p_drain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && !zc_flag) |=> (ls_en && fault));

    p_drain_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && zc_flag) |=> (!hs_en && !ls_en && fault));

    p_blank_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        off_now |-> (off_len_q < FULL));

    p_blank_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (off_len_q == FULL));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (hs_en && !fault));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(.BLANK_CYC(BLANK_CYC)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .uv_flag (uv_flag),
    .zc_flag (zc_flag),
    .hs_en   (hs_en),
    .ls_en   (ls_en),
    .fault   (fault),
    .restart (restart)
);

// File: tb/test_ocp_hiccup_ctrl.sv
module test_ocp_hiccup_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TRIP = 16;
    localparam int BLANK = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 1'b0, oc_flag = 1'b0, pgood = 1'b0, uv_flag = 1'b0, zc_flag = 1'b0;
    logic hs_en, ls_en, fault, restart;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model: 0 run, 1 drain, 2 off
    int m_st = 0, m_cnt = 0, m_tmr = 0;
    bit m_rst = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_hiccup_ctrl #(.TRIP_CNT(TRIP), .BLANK_CYC(BLANK)) i_ocp_hiccup_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .oc_flag(oc_flag),
        .pgood(pgood), .uv_flag(uv_flag), .zc_flag(zc_flag),
        .hs_en(hs_en), .ls_en(ls_en), .fault(fault), .restart(restart)
    );

    function automatic bit exp_hs(int st);    return st == 0; endfunction
    function automatic bit exp_ls(int st);    return st == 1; endfunction
    function automatic bit exp_fault(int st); return st != 0; endfunction
    function automatic string req_of(int st);
        case (st)
            0: return "R2";
            1: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic model_step();
        bit qual, trip;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tmr = 0; m_rst = 1'b0;
            return;
        end
        m_rst = 1'b0;
        case (m_st)
            0: begin
                qual = cyc_tick && oc_flag && !pgood;
                trip = qual && (m_cnt >= TRIP - 1);
                if (cyc_tick) m_cnt = qual ? ((m_cnt < TRIP) ? m_cnt + 1 : m_cnt) : 0;
                if (trip || uv_flag) begin m_st = 1; m_cnt = 0; end
            end
            1: begin
                m_cnt = 0;
                if (zc_flag) begin m_st = 2; m_tmr = 0; end
            end
            default: begin
                m_cnt = 0;
                if (m_tmr == BLANK - 1) begin m_st = 0; m_rst = 1'b1; end
                else m_tmr++;
            end
        endcase
    endtask

    task automatic compare_all();
        string rq;
        rq = req_of(m_st);
        chk(hs_en == exp_hs(m_st), rq, "hs_en", hs_en, exp_hs(m_st));
        chk(ls_en == exp_ls(m_st), rq, "ls_en", ls_en, exp_ls(m_st));
        chk(fault == exp_fault(m_st), rq, "fault", fault, exp_fault(m_st));
        chk(restart == m_rst, "R7", "restart", restart, m_rst);
        chk(!(hs_en && ls_en), "R8", "hs&ls", hs_en && ls_en, 0);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        cyc_tick = 0; oc_flag = 0; pgood = 0; uv_flag = 0; zc_flag = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        cycle(); cycle();
        chk(hs_en && !ls_en && !fault && !restart, "R1", "reset outputs",
            {hs_en, ls_en, fault, restart}, 4'b1000);
        rst_n = 1'b1;
        cycle();
        chk(hs_en && !ls_en && !fault && !restart, "R1", "post-reset outputs",
            {hs_en, ls_en, fault, restart}, 4'b1000);
    endtask

    // one qualifying tick followed by one idle clock
    task automatic qual_tick(input bit o, input bit pg);
        cyc_tick = 1; oc_flag = o; pgood = pg;
        cycle();
        cyc_tick = 0;
        cycle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R2: fifteen qualifying ticks do not trip, the sixteenth does
        for (int i = 0; i < TRIP - 1; i++) qual_tick(1, 0);
        chk(!fault && hs_en, "R2", "no trip after 15", fault, 0);
        cyc_tick = 1; oc_flag = 1; pgood = 0;
        cycle();
        chk(fault && ls_en && !hs_en, "R2", "trip on 16th", fault, 1);
        idle_inputs();

        // R5 / R9: stay draining, over-current and uv ignored
        oc_flag = 1; uv_flag = 1; cyc_tick = 1;
        for (int i = 0; i < 5; i++) cycle();
        chk(ls_en && fault, "R5", "drain hold", ls_en, 1);
        idle_inputs();
        zc_flag = 1;
        cycle();
        zc_flag = 0;
        chk(!hs_en && !ls_en && fault, "R5", "enter off on zc", ls_en, 0);

        // R6 / R7: off time exactly BLANK cycles, then restart pulse
        uv_flag = 1; // R9: ignored in off state
        for (int i = 0; i < BLANK - 1; i++) cycle();
        chk(fault && !restart, "R6", "still off", fault, 1);
        uv_flag = 0;
        cycle();
        chk(restart && hs_en && !fault, "R7", "restart pulse", restart, 1);
        cycle();
        chk(!restart, "R7", "pulse one cycle", restart, 0);

        // R7: persisting overload trips again after a full count
        for (int i = 0; i < TRIP - 1; i++) qual_tick(1, 0);
        chk(!fault, "R7", "count restarted from zero", fault, 0);
        cyc_tick = 1; oc_flag = 1;
        cycle();
        chk(fault, "R7", "second hiccup", fault, 1);

        // R3: clean tick clears the count
        do_reset();
        for (int i = 0; i < 10; i++) qual_tick(1, 0);
        qual_tick(0, 0);
        for (int i = 0; i < TRIP - 1; i++) qual_tick(1, 0);
        chk(!fault, "R3", "clean tick clears", fault, 0);
        // R3: power-good tick clears
        qual_tick(1, 1);
        for (int i = 0; i < TRIP - 1; i++) qual_tick(1, 0);
        chk(!fault, "R3", "pgood tick clears", fault, 0);
        // R3: clocks without tick hold the count
        oc_flag = 1; cyc_tick = 0;
        for (int i = 0; i < 7; i++) cycle();
        cyc_tick = 1;
        cycle();
        chk(fault, "R3", "idle clocks keep count", fault, 1);

        // R9: zc in run ignored; R4: uv trips at once
        do_reset();
        zc_flag = 1;
        for (int i = 0; i < 4; i++) cycle();
        chk(hs_en && !fault, "R9", "zc ignored in run", fault, 0);
        zc_flag = 0; uv_flag = 1;
        cycle();
        uv_flag = 0;
        chk(fault && ls_en, "R4", "uv immediate trip", fault, 1);

        // random phase
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            bit burst;
            burst = ((i / 400) % 2) == 1;
            cyc_tick = ($urandom % 3) == 0;
            oc_flag  = burst ? (($urandom % 20) != 0) : (($urandom % 4) == 0);
            pgood    = ($urandom % 10) == 0;
            uv_flag  = ($urandom % 300) == 0;
            zc_flag  = ($urandom % 5) == 0;
            if (($urandom % 1500) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            cycle();
        end
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule